// File: doc/BRIEF.md
# Qualified Remote CRC Error Counter

This block sits on an E1 receive path behind frame alignment and CRC-4 processing. It counts the submultiframes that the far end reports as errored, but only while that far end is also signalling a remote alarm. Such a count shows how many CRC-4 blocks the remote side saw corrupted during a period when it had lost layer-one service.

Two kinds of strobe feed the counter. The first comes once per frame carrying the non-frame-alignment word. It delivers the remote alarm bit, which the block holds until the next such frame. The second comes once per submultiframe report and delivers the received E-bit. A zero E-bit that arrives while the held alarm is set advances the count by one. A host reads the count and can zero it with a synchronous clear.

The block keeps two sticky event flags: a toggle flag and a wrap flag. The host clears each flag with a write-one-to-clear input. A mask vector selects which flags reach the single interrupt line.

Top module: `rem_crc_err_cnt`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `count_o` is 0, `flag_o` is 2'b00, `irq_o` is 0 and the held alarm is 0.
- R2: An E-bit strobe with value 0 that arrives while the held alarm is 1 raises `count_o` by exactly one on the next cycle. Strobes in consecutive cycles each count.
- R3: The count does not change when there is no E-bit strobe, when the strobed E-bit is 1, or when the held alarm is 0.
- R4: A non-frame-alignment strobe loads its alarm bit into the held alarm. An E-bit strobe in the same cycle as that strobe is qualified by the previously held value.
- R5: Flag bit 0 (toggle) is set on the cycle after any increment, that is, whenever bit 0 of the count changes value.
- R6: Flag bit 1 (wrap) is set on the cycle after the count rolls from all ones (0xFF at the default width) to zero.
- R7: Flags stay set until their bit of `flag_w1c_i` is 1. A new event in the same cycle as its clear leaves the flag set.
- R8: `irq_o` is 1 exactly when some flag is set whose bit in `irq_mask_i` is 1. The mask never stops a flag from being set.
- R9: `clr_i` zeroes the count on the next cycle. It overrides an increment in the same cycle and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nfas_vld_i | input | 1 | Strobe: a non-frame-alignment word was received |
| nfas_alarm_i | input | 1 | Remote alarm bit of that word |
| ebit_vld_i | input | 1 | Strobe: an E-bit report was received |
| ebit_val_i | input | 1 | Received E-bit value (0 means a remote error) |
| clr_i | input | 1 | Synchronous clear of the count |
| flag_w1c_i | input | 2 | Write-one-to-clear for the flags |
| irq_mask_i | input | 2 | Interrupt enable per flag (bit 0 toggle, bit 1 wrap) |
| count_o | output | CNT_W (8) | Qualified error count |
| flag_o | output | 2 | Sticky flags (bit 0 toggle, bit 1 wrap) |
| irq_o | output | 1 | Interrupt request |

## Verification
Several rules are checked by properties on every cycle:
- the count moves by exactly one after a qualified strobe and holds otherwise;
- a clear zeroes the count and raises no flag;
- flags stay set until their clear bit arrives;
- any change of the low count bit, and any roll from all ones to zero, leaves the matching flag set;
- the interrupt stays low while every set flag is masked.

Some behaviour can only be shown by the bench's scenarios. These include using the old alarm when a frame strobe and an E-bit strobe share a cycle, a flag that survives its own clear, and a full 256-step run up to the wrap.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

    // flag vector layout
    localparam int unsigned FLG_TOG  = 0;
    localparam int unsigned FLG_WRAP = 1;
    localparam int unsigned NFLG     = 2;

    typedef logic [NFLG-1:0] flag_vec_t;

endpackage

// File: rtl/rcc_alarm_hold.sv
module rcc_alarm_hold (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic nfas_vld_i,
    input  logic nfas_alarm_i,
    output logic alarm_o
);

    typedef struct packed {
        logic alarm;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (nfas_vld_i) begin
            st_d.alarm = nfas_alarm_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // registered value: a same-cycle E-bit strobe sees the old alarm
    assign alarm_o = st_q.alarm;

endmodule

// File: rtl/rcc_err_count.sv
module rcc_err_count #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ebit_vld_i,
    input  logic             ebit_val_i,
    input  logic             alarm_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ev_tog_o,
    output logic             ev_wrap_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    qual_err;

    always_comb begin
        qual_err  = ebit_vld_i && !ebit_val_i && alarm_i;
        st_d      = st_q;
        ev_tog_o  = 1'b0;
        ev_wrap_o = 1'b0;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (qual_err) begin
            st_d.cnt  = st_q.cnt + 1'b1;
            ev_tog_o  = 1'b1;
            ev_wrap_o = (st_q.cnt == CNT_MAX);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;

endmodule

// File: rtl/rcc_irq_flags.sv
module rcc_irq_flags
    import rcc_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  flag_vec_t ev_i,
    input  flag_vec_t w1c_i,
    input  flag_vec_t mask_i,
    output flag_vec_t flag_o,
    output logic      irq_o
);

    typedef struct packed {
        flag_vec_t flg;
    } flg_st_t;

    flg_st_t   st_d, st_q;
    flag_vec_t live;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NFLG; i++) begin
            // a fresh event beats its own clear
            st_d.flg[i] = (st_q.flg[i] && !w1c_i[i]) || ev_i[i];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NFLG; g++) begin : g_live
        assign live[g] = st_q.flg[g] & mask_i[g];
    end

    assign flag_o = st_q.flg;
    assign irq_o  = |live;

endmodule

// File: rtl/rem_crc_err_cnt.sv
module rem_crc_err_cnt
    import rcc_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             nfas_vld_i,
    input  logic             nfas_alarm_i,
    input  logic             ebit_vld_i,
    input  logic             ebit_val_i,
    input  logic             clr_i,
    input  logic [1:0]       flag_w1c_i,
    input  logic [1:0]       irq_mask_i,
    output logic [CNT_W-1:0] count_o,
    output logic [1:0]       flag_o,
    output logic             irq_o
);

    logic      alarm_held;
    logic      ev_tog;
    logic      ev_wrap;
    flag_vec_t ev_vec;

    rcc_alarm_hold i_alarm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .nfas_vld_i  (nfas_vld_i),
        .nfas_alarm_i(nfas_alarm_i),
        .alarm_o     (alarm_held)
    );

    rcc_err_count #(.CNT_W(CNT_W)) i_count (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ebit_vld_i(ebit_vld_i),
        .ebit_val_i(ebit_val_i),
        .alarm_i   (alarm_held),
        .clr_i     (clr_i),
        .count_o   (count_o),
        .ev_tog_o  (ev_tog),
        .ev_wrap_o (ev_wrap)
    );

    always_comb begin
        ev_vec           = '0;
        ev_vec[FLG_TOG]  = ev_tog;
        ev_vec[FLG_WRAP] = ev_wrap;
    end

    rcc_irq_flags i_flags (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .ev_i  (ev_vec),
        .w1c_i (flag_w1c_i),
        .mask_i(irq_mask_i),
        .flag_o(flag_o),
        .irq_o (irq_o)
    );

endmodule

// File: rtl/rcc_checker.sv
module rcc_checker #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             alarm_held,
    input logic             ebit_vld_i,
    input logic             ebit_val_i,
    input logic             clr_i,
    input logic [1:0]       flag_w1c_i,
    input logic [1:0]       irq_mask_i,
    input logic [CNT_W-1:0] count_o,
    input logic [1:0]       flag_o,
    input logic             irq_o
);

    logic qual;
    assign qual = ebit_vld_i && !ebit_val_i && alarm_held;

    AST_INC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (qual && !clr_i) |=> (count_o == CNT_W'($past(count_o) + 1'b1))); // R2

    AST_COUNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!qual && !clr_i) |=> $stable(count_o)); // R3

    AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (count_o == '0)); // R9

    AST_CLR_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (flag_o == ($past(flag_o) & ~$past(flag_w1c_i)))); // R9

    AST_TOG_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((count_o[0] != $past(count_o[0])) && !$past(clr_i)) |-> flag_o[0]); // R5

    AST_WRAP_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (($past(count_o) == {CNT_W{1'b1}}) && (count_o == '0) && !$past(clr_i)) |-> flag_o[1]); // R6

    AST_TOG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_o[0] && !flag_w1c_i[0]) |=> flag_o[0]); // R7

    AST_WRAP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_o[1] && !flag_w1c_i[1]) |=> flag_o[1]); // R7

    AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((flag_o & irq_mask_i) == 2'b00) |-> !irq_o); // R8

endmodule

bind rem_crc_err_cnt rcc_checker #(.CNT_W(CNT_W)) i_rcc_checker (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .alarm_held(alarm_held),
    .ebit_vld_i(ebit_vld_i),
    .ebit_val_i(ebit_val_i),
    .clr_i     (clr_i),
    .flag_w1c_i(flag_w1c_i),
    .irq_mask_i(irq_mask_i),
    .count_o   (count_o),
    .flag_o    (flag_o),
    .irq_o     (irq_o)
);

// File: tb/test_rem_crc_err_cnt.sv
module test_rem_crc_err_cnt;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       nfas_vld_i = 1'b0, nfas_alarm_i = 1'b0;
    logic       ebit_vld_i = 1'b0, ebit_val_i = 1'b1;
    logic       clr_i = 1'b0;
    logic [1:0] flag_w1c_i = 2'b00, irq_mask_i = 2'b00;
    logic [7:0] count_o;
    logic [1:0] flag_o;
    logic       irq_o;

    always #10 clk_i = ~clk_i; // 50 MHz

    rem_crc_err_cnt #(.CNT_W(8)) i_rem_crc_err_cnt (.*);

    typedef struct {
        logic [7:0] cnt;
        logic [1:0] flg;
        logic       irq;
        string      tag;
    } exp_t;

    exp_t expq[$];
    int   n_chk = 0, n_bad = 0;

    // reference state
    logic       m_alarm = 1'b0;
    logic [7:0] m_cnt = 8'd0;
    logic [1:0] m_flg = 2'b00;

    task automatic compare(input exp_t e);
        n_chk++;
        if (count_o !== e.cnt || flag_o !== e.flg || irq_o !== e.irq) begin
            n_bad++;
            $display("FAIL %s: got cnt=%0d flg=%b irq=%b, expected cnt=%0d flg=%b irq=%b",
                     e.tag, count_o, flag_o, irq_o, e.cnt, e.flg, e.irq);
        end
    endtask

    // driver: applies one cycle of stimulus and pushes the expected result
    task automatic step(input logic nv, input logic na, input logic ev, input logic eb,
                        input logic cl, input logic [1:0] w1c, input logic [1:0] msk,
                        input string tag);
        logic       inc;
        logic [1:0] evv;
        exp_t       e;
        @(negedge clk_i);
        #1;
        nfas_vld_i = nv; nfas_alarm_i = na; ebit_vld_i = ev; ebit_val_i = eb;
        clr_i = cl; flag_w1c_i = w1c; irq_mask_i = msk;
        inc = ev && !eb && m_alarm && !cl;
        evv = {inc && (m_cnt == 8'hFF), inc};
        m_cnt = cl ? 8'd0 : (inc ? m_cnt + 8'd1 : m_cnt);
        m_flg = (m_flg & ~w1c) | evv;
        if (nv) m_alarm = na;
        e.cnt = m_cnt; e.flg = m_flg; e.irq = |(m_flg & msk); e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic idle(input logic [1:0] msk, input string tag);
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, msk, tag);
    endtask

    // monitor: compares at the falling edge, inputs change only after it
    always @(negedge clk_i) begin
        if (rst_ni && expq.size() > 0) begin
            compare(expq.pop_front());
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk_i);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        exp_t r;
        repeat (3) @(negedge clk_i);
        r.cnt = 0; r.flg = 0; r.irq = 0; r.tag = "R1 in reset";
        compare(r);
        #1 rst_ni = 1'b1;
        idle(2'b11, "R1 after reset");

        // no alarm held: error E-bit ignored
        step(0, 0, 1, 0, 0, 2'b00, 2'b00, "R3 no alarm");
        step(1, 1, 0, 1, 0, 2'b00, 2'b00, "R4 load alarm");
        step(0, 0, 1, 1, 0, 2'b00, 2'b00, "R3 ebit one");
        step(0, 0, 1, 0, 0, 2'b00, 2'b00, "R2 R5 first inc");
        step(0, 0, 1, 0, 0, 2'b00, 2'b01, "R2 back to back, R8 masked in");
        idle(2'b00, "R8 mask off");
        idle(2'b10, "R8 other mask");
        // same-cycle frame strobe uses old alarm
        step(1, 0, 1, 0, 0, 2'b00, 2'b00, "R4 old alarm counts");
        step(0, 0, 1, 0, 0, 2'b00, 2'b00, "R4 new alarm blocks");
        // clear with event vs clear alone
        step(1, 1, 0, 1, 0, 2'b00, 2'b00, "R4 reload alarm");
        step(0, 0, 1, 0, 0, 2'b01, 2'b01, "R7 event beats clear");
        step(0, 0, 0, 1, 0, 2'b01, 2'b01, "R7 w1c clears");
        idle(2'b01, "R7 stays clear");
        step(0, 0, 1, 0, 1, 2'b00, 2'b11, "R9 clear beats inc");
        idle(2'b11, "R9 no flag raised");

        // run to wrap: 255 increments, then one more
        for (int i = 0; i < 255; i++) begin
            step(0, 0, 1, 0, 0, 2'b01, 2'b10, "R2 ramp");
        end
        step(0, 0, 1, 0, 0, 2'b00, 2'b10, "R6 wrap to zero");
        idle(2'b10, "R6 wrap flag held, R8 irq");
        step(0, 0, 0, 1, 0, 2'b10, 2'b10, "R7 wrap cleared");
        step(0, 0, 1, 0, 0, 2'b00, 2'b10, "R6 no wrap on 0 to 1");
        idle(2'b00, "R3 idle");
        repeat (3) @(negedge clk_i);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule